// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Interrupt

This peripheral keeps a free-running 32-bit count of seconds and raises an interrupt when that count reaches a programmed match value. One second is defined by a prescaler that counts `PRESCALE` cycles of the input clock. Software talks to it over a simple word-addressed register bus: address, write strobe, read strobe and 32-bit data in each direction.

A new time is written to a load register. It is not copied into the counter at once. It waits as a pending value until the next one-second update replaces the normal increment with it. The match event is latched into a raw status flag whatever the interrupt settings are. An enable bit and a mask bit gate that flag onto the interrupt pin and the masked status register. Software acknowledges the event by reading the end-of-interrupt register. With the wrap bit set, each match also reloads the counter from the load register, which turns the block into a periodic seconds alarm.

Top module: `sec_rtc`

## Requirements
- R1: After synchronous reset the counter, match, load and control registers and both status bits read 0. The interrupt output is low. The version register at 0x1C reads the `VERSION` parameter.
- R2: The counter (0x00) advances by one each `PRESCALE` clock cycles (PRESCALE >= 2) only while control bit 2 (count enable) is 1. While that bit is 0 the counter holds its value.
- R3: A write to the load register (0x08) leaves the counter unchanged until the next one-second update, and the counter then takes the written value. The load register reads back the written value.
- R4: On an update at which the counter equals the match register (0x04), raw status bit 0 (0x14) becomes 1 whether or not the interrupt is enabled.
- R5: The interrupt output and masked status bit 0 (0x10) equal raw AND control bit 0 (interrupt enable) AND NOT control bit 1 (mask). They are registered and follow one cycle after their inputs.
- R6: A read of 0x18 clears the raw status. A match on the same cycle keeps it set.
- R7: With control bit 3 (wrap enable) set, an update at which the counter equals the match value loads the counter from the load register instead of incrementing it.
- R8: With wrap enable clear, the counter keeps counting through a match and rolls over from 0xFFFFFFFF to 0.
- R9: Writes to 0x00, 0x10, 0x14, 0x18 and 0x1C change no register.
- R10: The control register at 0x0C stores only bits 3:0 and reads back with bits 31:4 at 0.
- R11: Read data is registered: it appears on `bus_rdata` in the cycle after the read strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the time base for the prescaler |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register (word aligned) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Match interrupt, gated by enable and mask |

## Verification
A wrong prescaler phase or a lost pending load shows up as a counter value that is off by one or more whole seconds. That value can be read one cycle after the read strobe, as soon as the run has been frozen by clearing count enable. A raw flag that is set at the wrong moment, or cleared when it should not be, shows up at the next status read or at the `irq` pin one cycle later. Wrap and rollover faults show up in the counter value read just after the match second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 5;
  localparam int CTRL_W = 4;

  localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_MATCH = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_LOAD  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_MSTAT = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_RSTAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_ACK   = 5'h18;
  localparam logic [ADDR_W-1:0] OFF_VER   = 5'h1C;

  localparam int CB_IE   = 0;
  localparam int CB_MASK = 1;
  localparam int CB_EN   = 2;
  localparam int CB_WRAP = 3;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] match_val,
  input  logic              wrap_en,
  input  logic              ack_rd,
  output logic [DATA_W-1:0] count_q,
  output logic              raw_q
);
  logic pend_q;
  logic hit;

  assign hit = (count_q == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pend_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else if (tick) begin
      if (pend_q || (wrap_en && hit)) count_q <= load_val;
      else                            count_q <= count_q + 1'b1;
      pend_q <= load_wr;
      if (hit)         raw_q <= 1'b1;
      else if (ack_rd) raw_q <= 1'b0;
    end else begin
      if (load_wr) pend_q <= 1'b1;
      if (ack_rd)  raw_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count,
  input  logic              raw,
  input  logic              masked,
  output logic [DATA_W-1:0] match_q,
  output logic [DATA_W-1:0] load_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              load_wr,
  output logic              ack_rd,
  output logic [DATA_W-1:0] rdata_q
);
  assign load_wr = wr && (addr == OFF_LOAD);
  assign ack_rd  = rd && (addr == OFF_ACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      load_q  <= '0;
      ctrl_q  <= '0;
    end else if (wr) begin
      case (addr)
        OFF_MATCH: match_q <= wdata;
        OFF_LOAD:  load_q  <= wdata;
        OFF_CTRL:  ctrl_q  <= wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      case (addr)
        OFF_COUNT: rdata_q <= count;
        OFF_MATCH: rdata_q <= match_q;
        OFF_LOAD:  rdata_q <= load_q;
        OFF_CTRL:  rdata_q <= DATA_W'(ctrl_q);
        OFF_MSTAT: rdata_q <= DATA_W'(masked);
        OFF_RSTAT: rdata_q <= DATA_W'(raw);
        OFF_VER:   rdata_q <= DATA_W'(VERSION);
        default:   rdata_q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int          PRESCALE = 1000,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] VERSION  = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] match_q, load_q, count_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              load_wr, ack_rd, tick, raw_q, run_en, irq_q;

  assign run_en = ctrl_q[CB_EN];

  rtc_regs #(.DATA_W(DATA_W), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .count(count_q), .raw(raw_q), .masked(irq_q),
    .match_q(match_q), .load_q(load_q), .ctrl_q(ctrl_q),
    .load_wr(load_wr), .ack_rd(ack_rd), .rdata_q(bus_rdata)
  );

  rtc_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .run(run_en), .tick(tick)
  );

  rtc_time_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .load_wr(load_wr),
    .load_val(load_q), .match_val(match_q), .wrap_en(ctrl_q[CB_WRAP]),
    .ack_rd(ack_rd), .count_q(count_q), .raw_q(raw_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= raw_q && ctrl_q[CB_IE] && !ctrl_q[CB_MASK];
  end

  assign irq = irq_q;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              run,
  input logic [DATA_W-1:0] count,
  input logic              raw,
  input logic              irq,
  input logic              ack_rd
);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R2
  run_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count));
  // R4
  raw_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw) |-> $past(tick));
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_rd && !tick) |=> !raw);
  // R5
  irq_raw_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(raw));
endmodule

bind sec_rtc rtc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .run(run_en), .count(count_q),
  .raw(raw_q), .irq(irq), .ack_rd(ack_rd)
);

// File: tb/test_sec_rtc.sv
module test_sec_rtc;
  localparam int          P   = 4;
  localparam logic [31:0] VER = 32'hA5C3_0102;
  localparam logic [4:0] A_CNT = 5'h00, A_MAT = 5'h04, A_LD = 5'h08, A_CTL = 5'h0C,
                         A_MST = 5'h10, A_RST = 5'h14, A_ACK = 5'h18, A_VER = 5'h1C;
  localparam logic [31:0] IE = 32'h1, MSK = 32'h2, EN = 32'h4, WRP = 32'h8;

  logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, irq;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sec_rtc #(.PRESCALE(P), .DATA_W(32), .VERSION(VER)) i_sec_rtc (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // run exactly n seconds with count enable on, then freeze
  task automatic run_secs(input logic [31:0] bits, input int n);
    wr(A_CTL, bits | EN);
    repeat (n * P - 1) @(posedge clk);
    wr(A_CTL, bits);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 irq", {31'b0, irq}, 0);
    rd(A_CNT, d); check("R1 count", d, 0);
    rd(A_MAT, d); check("R1 match", d, 0);
    rd(A_LD,  d); check("R1 load", d, 0);
    rd(A_CTL, d); check("R1 ctrl", d, 0);
    rd(A_MST, d); check("R1 masked", d, 0);
    rd(A_RST, d); check("R1 raw", d, 0);
    rd(A_VER, d); check("R1 version", d, VER);
  endtask

  task automatic t_hold_and_count();
    logic [31:0] d;
    do_reset();
    wr(A_MAT, 32'hFFFF);
    repeat (5 * P) @(posedge clk);
    rd(A_CNT, d); check("R2 hold when disabled", d, 0);
    run_secs(0, 3);
    rd(A_CNT, d); check("R2 three seconds", d, 3);
    repeat (3 * P) @(posedge clk);
    rd(A_CNT, d); check("R2 frozen", d, 3);
  endtask

  task automatic t_load_defer();
    logic [31:0] d;
    do_reset();
    wr(A_MAT, 32'hFFFF);
    run_secs(0, 2);
    wr(A_LD, 32'd100);
    rd(A_CNT, d); check("R3 not immediate", d, 2);
    rd(A_LD, d);  check("R3 load readback", d, 100);
    run_secs(0, 1);
    rd(A_CNT, d); check("R3 taken at tick", d, 100);
    run_secs(0, 1);
    rd(A_CNT, d); check("R3 then increments", d, 101);
  endtask

  task automatic t_match_irq();
    logic [31:0] d;
    do_reset();
    wr(A_MAT, 32'd12); wr(A_LD, 32'd10);
    run_secs(IE, 3);
    rd(A_CNT, d); check("R4 count before match", d, 12);
    rd(A_RST, d); check("R4 raw before match", d, 0);
    run_secs(IE, 1);
    rd(A_RST, d); check("R4 raw at match", d, 1);
    rd(A_MST, d); check("R5 masked at match", d, 1);
    check("R5 irq at match", {31'b0, irq}, 1);
    rd(A_CNT, d); check("R8 counts past match", d, 13);
    rd(A_ACK, d);
    rd(A_RST, d); check("R6 raw cleared", d, 0);
    check("R6 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_reset();
    wr(A_MAT, 32'd2);
    run_secs(0, 3);
    rd(A_RST, d); check("R4 raw without enable", d, 1);
    check("R5 irq off, ie=0", {31'b0, irq}, 0);
    wr(A_CTL, IE | MSK);
    rd(A_MST, d); check("R5 masked status, mask=1", d, 0);
    check("R5 irq off, mask=1", {31'b0, irq}, 0);
    wr(A_CTL, IE);
    rd(A_MST, d); check("R5 masked status, mask=0", d, 1);
    check("R5 irq on", {31'b0, irq}, 1);
    wr(A_CTL, 0);
    rd(A_RST, d); check("R5 raw kept after disable", d, 1);
    check("R5 irq off after disable", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    do_reset();
    wr(A_MAT, 32'd7); wr(A_LD, 32'd5);
    run_secs(WRP, 5);
    rd(A_CNT, d); check("R7 reload on match", d, 6);
    rd(A_RST, d); check("R7 raw on wrap match", d, 1);
    do_reset();
    wr(A_MAT, 32'd7); wr(A_LD, 32'd5);
    run_secs(0, 5);
    rd(A_CNT, d); check("R8 no reload without wrap", d, 9);
  endtask

  task automatic t_rollover();
    logic [31:0] d;
    do_reset();
    wr(A_MAT, 32'd5); wr(A_LD, 32'hFFFF_FFFE);
    run_secs(0, 2);
    rd(A_CNT, d); check("R8 at max", d, 32'hFFFF_FFFF);
    run_secs(0, 1);
    rd(A_CNT, d); check("R8 rolled to zero", d, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    do_reset();
    wr(A_CNT, 32'hDEAD); wr(A_VER, 32'h1234); wr(A_RST, 32'h1);
    wr(A_MST, 32'h1); wr(A_ACK, 32'hFF);
    rd(A_CNT, d); check("R9 count write ignored", d, 0);
    rd(A_VER, d); check("R9 version write ignored", d, VER);
    rd(A_RST, d); check("R9 raw write ignored", d, 0);
    rd(A_MAT, d); check("R9 match untouched", d, 0);
    wr(A_CTL, 32'hFFFF_FFF3);
    rd(A_CTL, d); check("R10 ctrl width", d, 32'h3);
  endtask

  task automatic t_read_latency();
    do_reset();
    wr(A_MAT, 32'h55AA);
    @(negedge clk); bus_addr = A_MAT; bus_rd = 1'b1;
    check("R11 before edge", bus_rdata, 0);
    @(posedge clk);
    @(negedge clk); bus_rd = 1'b0;
    check("R11 after edge", bus_rdata, 32'h55AA);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold_and_count();
    t_load_defer();
    t_match_irq();
    t_mask();
    t_wrap();
    t_rollover();
    t_ignored();
    t_read_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule